// File: doc/BRIEF.md
# Authenticated Firmware Load Controller

This block fetches a firmware image from source memory and places it in a local storage RAM, but only after an external authentication-success flag approves the load. A load command carries an 8-bit image descriptor, a source byte offset and a length counted in 64-byte lines. After the command is accepted, the controller spends one cycle on screening. A descriptor of zero is illegal. A zero length, a length above the RAM capacity, or an offset that is not line aligned is also refused. If the command passes those tests, the authentication input is sampled once in that same cycle. A command that fails any of these tests is aborted: nothing is read and nothing is written.

An approved command is copied one line at a time. Each line is a single read request on a request/response port toward source memory, followed by one write into the RAM. The source address and the RAM line index both advance by one line (64 bytes) per transfer. The valid-loaded status bit rises only after the final line has been written. Any new command clears it. A registered read port lets the consuming processor fetch lines from the RAM.

States: Idle (ready for a command), Check (screen and sample authentication), Request (issue one line read), Wait (await the line data and write it), Finish (set valid-loaded). Transitions: Idle→Check on acceptance; Check→Idle on any refusal; Check→Request when approved; Request→Wait when the read is taken; Wait→Request on a response that is not the last line; Wait→Finish on the last line's response; Finish→Idle always.

Top module: `fwl_load_ctrl`

## Requirements
- R1: `cmd_ready` is high only in Idle. From the acceptance edge it stays low until the sequence ends: 1 edge for a refused command, and 2+2N edges for an N-line copy when the responder is always ready and answers one cycle after taking a request.
- R2: The acceptance edge clears `loaded` to 0 and `err_code` to 0, including when `loaded` was 1 from an earlier load.
- R3: A descriptor of 0 gives `err_code` = 2. No read request is issued, no RAM line is written, and `loaded` stays 0.
- R4: A length of 0, a length above 1536 lines (96 KB), or a source offset whose bits [5:0] are nonzero gives `err_code` = 3 and the same abort. A length of exactly 1536 lines is accepted.
- R5: `auth_ok` is sampled only on the Check edge, one edge after acceptance. If it is low there, `err_code` = 1 and the load aborts. The checks apply in priority order: descriptor (2) first, then size (3), then authentication (1).
- R6: For line k of an approved load, `rd_req_addr` = offset + 64·k and `rd_req_desc` = the descriptor. The returned line is written to RAM line k. Exactly N requests are issued.
- R7: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and its address does not change.
- R8: `loaded` rises on the edge after the last line's write, with `err_code` = 0.
- R9: `ex_data` shows RAM line `ex_addr` one clock edge after the address is presented, not before.
- R10: Changes on `auth_ok` after the Check edge have no effect on a copy in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Load command offered |
| cmd_ready | output | 1 | Controller idle, command may be taken |
| cmd_desc | input | 8 | Image descriptor, 0 illegal |
| cmd_src | input | ADDR_W (32) | Source byte offset, must be line aligned |
| cmd_lines | input | LEN_W (16) | Image length in 64-byte lines |
| auth_ok | input | 1 | Authentication-success flag |
| rd_req_valid | output | 1 | Line read request valid |
| rd_req_ready | input | 1 | Source memory takes the request |
| rd_req_addr | output | ADDR_W (32) | Byte address of the requested line |
| rd_req_desc | output | 8 | Descriptor of the image being read |
| rd_rsp_valid | input | 1 | Line data returned |
| rd_rsp_data | input | LINE_W (512) | One line of image data |
| ex_addr | input | IDX_W (11) | RAM line index to read |
| ex_data | output | LINE_W (512) | Registered RAM read data |
| loaded | output | 1 | Valid-loaded status bit |
| err_code | output | 2 | 0 none, 1 authentication, 2 descriptor, 3 size/alignment |

## Verification
A refused command settles its error code and raises `cmd_ready` on the Check edge, one edge after acceptance. An approved N-line copy sets `loaded` 2+2N edges after acceptance when the bench's responder answers one cycle after each taken request. The bench counts clock edges from acceptance until `cmd_ready` returns. It samples on the falling edge that follows, and compares the count with these figures. RAM contents are read back through the registered port, with one edge allowed between address and data. A stalling responder run checks only the contents and the request count, because the timing figures do not apply to it.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_REQ,
        S_WAIT,
        S_FINISH
    } fwl_state_e;

    typedef enum logic [1:0] {
        E_NONE = 2'd0,
        E_AUTH = 2'd1,
        E_DESC = 2'd2,
        E_SIZE = 2'd3
    } fwl_err_e;

endpackage

// File: rtl/fwl_cmd_check.sv
module fwl_cmd_check
    import fwl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int OFF_BITS  = 6,
    parameter int MAX_LINES = 1536
) (
    input  logic [7:0]        desc,
    input  logic [ADDR_W-1:0] src,
    input  logic [LEN_W-1:0]  lines,
    input  logic              auth_ok,
    output fwl_err_e          verdict
);

    logic bad_size;

    // Size screening: empty, oversize, or misaligned source.
    always_comb begin
        bad_size = (lines == '0)
                || (lines > LEN_W'(MAX_LINES))
                || (src[OFF_BITS-1:0] != '0);
    end

    // Priority: descriptor, then size, then authentication.
    always_comb begin
        if (desc == 8'd0) begin
            verdict = E_DESC;
        end else if (bad_size) begin
            verdict = E_SIZE;
        end else if (!auth_ok) begin
            verdict = E_AUTH;
        end else begin
            verdict = E_NONE;
        end
    end

endmodule

// File: rtl/fwl_line_seq.sv
module fwl_line_seq #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int OFF_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [LEN_W-1:0]  start_lines,
    input  logic              adv,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  lines_o,
    output logic [LEN_W-1:0]  count_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  lines_q;
    logic [LEN_W-1:0]  count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            lines_q <= '0;
            count_q <= '0;
        end else if (start) begin
            base_q  <= start_base;
            lines_q <= start_lines;
            count_q <= '0;
        end else if (adv) begin
            count_q <= count_q + LEN_W'(1);
        end
    end

    always_comb begin
        base_o  = base_q;
        lines_o = lines_q;
        count_o = count_q;
        addr_o  = base_q + (ADDR_W'(count_q) << OFF_BITS);
        last_o  = (count_q == (lines_q - LEN_W'(1)));
    end

endmodule

// File: rtl/fwl_store_ram.sv
module fwl_store_ram #(
    parameter int W     = 512,
    parameter int DEPTH = 1536,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/fwl_load_ctrl.sv
module fwl_load_ctrl
    import fwl_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int RAM_BYTES  = 98304,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int RAM_LINES = RAM_BYTES / LINE_BYTES,
    localparam int OFF_BITS  = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(RAM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_desc,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [LEN_W-1:0]  cmd_lines,
    input  logic              auth_ok,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [7:0]        rd_req_desc,
    input  logic              rd_rsp_valid,
    input  logic [LINE_W-1:0] rd_rsp_data,
    input  logic [IDX_W-1:0]  ex_addr,
    output logic [LINE_W-1:0] ex_data,
    output logic              loaded,
    output logic [1:0]        err_code
);

    fwl_state_e        state_q, state_d;
    fwl_err_e          err_q, verdict;
    logic              loaded_q;
    logic [7:0]        desc_q;
    logic              accept;
    logic              ram_we;
    logic              seq_adv;
    logic              seq_last;
    logic [ADDR_W-1:0] seq_base, seq_addr;
    logic [LEN_W-1:0]  seq_lines, seq_count;

    assign accept = cmd_valid && cmd_ready;

    fwl_line_seq #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .OFF_BITS(OFF_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_base (cmd_src),
        .start_lines(cmd_lines),
        .adv        (seq_adv),
        .base_o     (seq_base),
        .lines_o    (seq_lines),
        .count_o    (seq_count),
        .addr_o     (seq_addr),
        .last_o     (seq_last)
    );

    fwl_cmd_check #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .OFF_BITS (OFF_BITS),
        .MAX_LINES(RAM_LINES)
    ) u_check (
        .desc   (desc_q),
        .src    (seq_base),
        .lines  (seq_lines),
        .auth_ok(auth_ok),
        .verdict(verdict)
    );

    fwl_store_ram #(
        .W    (LINE_W),
        .DEPTH(RAM_LINES),
        .IDX_W(IDX_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(IDX_W'(seq_count)),
        .wdata(rd_rsp_data),
        .raddr(ex_addr),
        .rdata(ex_data)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_CHECK;
            S_CHECK:  state_d = (verdict == E_NONE) ? S_REQ : S_IDLE;
            S_REQ:    if (rd_req_ready) state_d = S_WAIT;
            S_WAIT:   if (rd_rsp_valid) state_d = seq_last ? S_FINISH : S_REQ;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        cmd_ready    = 1'b0;
        rd_req_valid = 1'b0;
        ram_we       = 1'b0;
        unique case (state_q)
            S_IDLE:   cmd_ready = 1'b1;
            S_CHECK:  ;
            S_REQ:    rd_req_valid = 1'b1;
            S_WAIT:   ram_we = rd_rsp_valid;
            S_FINISH: ;
            default:  ;
        endcase
        seq_adv     = ram_we;
        rd_req_addr = seq_addr;
        rd_req_desc = desc_q;
    end

    // Status and command registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            err_q    <= E_NONE;
            desc_q   <= 8'd0;
        end else if (accept) begin
            loaded_q <= 1'b0;
            err_q    <= E_NONE;
            desc_q   <= cmd_desc;
        end else if (state_q == S_CHECK && verdict != E_NONE) begin
            err_q    <= verdict;
        end else if (state_q == S_FINISH) begin
            loaded_q <= 1'b1;
        end
    end

    assign loaded   = loaded_q;
    assign err_code = err_q;

endmodule

// File: rtl/fwl_checker.sv
module fwl_checker #(
    parameter int ADDR_W   = 32,
    parameter int OFF_BITS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              loaded,
    input logic [1:0]        err_code
);

    a_r1_no_ready_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !cmd_ready);

    a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!loaded && err_code == 2'd0));

    a_r3_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> !rd_req_valid);

    a_r5_auth_fail_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 2'd1) |-> !loaded);

    a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[OFF_BITS-1:0] == '0));

    a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    a_r8_loaded_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded) |-> (err_code == 2'd0 && cmd_ready));

endmodule

bind fwl_load_ctrl fwl_checker #(
    .ADDR_W  (ADDR_W),
    .OFF_BITS(OFF_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .loaded      (loaded),
    .err_code    (err_code)
);

// File: tb/sim_fwl_load_ctrl.sv
module sim_fwl_load_ctrl;

    localparam int LINE_BYTES = 64;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int RAM_LINES  = 1536;
    localparam int IDX_W      = 11;

    typedef struct packed {
        logic [7:0]  desc;
        logic [31:0] src;
        logic [15:0] lines;
        logic        auth;
        logic [1:0]  err;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{8'd5,   32'h0000_1000, 16'd3,    1'b1, 2'd0},
        '{8'd200, 32'h0000_0040, 16'd1,    1'b1, 2'd0},
        '{8'd7,   32'h0000_2000, 16'd4,    1'b0, 2'd1},
        '{8'd0,   32'h0000_1000, 16'd2,    1'b1, 2'd2},
        '{8'd0,   32'h0000_1000, 16'd2,    1'b0, 2'd2},
        '{8'd9,   32'h0000_1010, 16'd2,    1'b1, 2'd3},
        '{8'd9,   32'h0000_1000, 16'd0,    1'b1, 2'd3},
        '{8'd9,   32'h0000_0000, 16'd1537, 1'b0, 2'd3},
        '{8'd255, 32'h0000_FFC0, 16'd6,    1'b1, 2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [7:0]        cmd_desc;
    logic [31:0]       cmd_src;
    logic [15:0]       cmd_lines;
    logic              auth_ok;
    logic              rd_req_valid;
    logic              rd_req_ready;
    logic [31:0]       rd_req_addr;
    logic [7:0]        rd_req_desc;
    logic              rd_rsp_valid;
    logic [LINE_W-1:0] rd_rsp_data;
    logic [IDX_W-1:0]  ex_addr;
    logic [LINE_W-1:0] ex_data;
    logic              loaded;
    logic [1:0]        err_code;

    int n_chk = 0;
    int n_bad = 0;
    int req_count = 0;
    bit stall = 1'b0;
    bit pend = 1'b0;
    logic [31:0] pend_addr;
    logic [7:0]  pend_desc;
    logic [LINE_W-1:0] exp_ram [0:RAM_LINES-1];
    bit known [0:RAM_LINES-1];

    always #10 clk = ~clk;

    fwl_load_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_desc    (cmd_desc),
        .cmd_src     (cmd_src),
        .cmd_lines   (cmd_lines),
        .auth_ok     (auth_ok),
        .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready),
        .rd_req_addr (rd_req_addr),
        .rd_req_desc (rd_req_desc),
        .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data (rd_rsp_data),
        .ex_addr     (ex_addr),
        .ex_data     (ex_data),
        .loaded      (loaded),
        .err_code    (err_code)
    );

    function automatic logic [LINE_W-1:0] img(input logic [31:0] a, input logic [7:0] d);
        logic [LINE_W-1:0] v;
        for (int i = 0; i < LINE_BYTES / 4; i++) begin
            v[i*32 +: 32] = (a + 32'(i * 4)) ^ {d, 8'h3C, d, 8'hC3};
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] e);
        case (e)
            2'd0:    return "R8";
            2'd1:    return "R5";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    // Source memory: answers one cycle after taking a request.
    initial begin
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        rd_req_ready = 1'b1;
        forever begin
            @(negedge clk);
            rd_rsp_valid = pend;
            rd_rsp_data  = pend ? img(pend_addr, pend_desc) : '0;
            rd_req_ready = stall ? ~rd_req_ready : 1'b1;
            pend = rd_req_valid && rd_req_ready && rst_n;
            if (pend) begin
                pend_addr = rd_req_addr;
                pend_desc = rd_req_desc;
                req_count++;
            end
        end
    end

    task automatic ram_read(input int idx, output logic [LINE_W-1:0] d);
        @(negedge clk);
        ex_addr = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        d = ex_data;
    endtask

    // Issue one command; returns edges from acceptance until cmd_ready is back.
    task automatic issue(input logic [7:0] desc, input logic [31:0] src, input logic [15:0] lines,
                         input logic auth_acc, input logic auth_chk, output int k);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1 idle ready", LINE_W'(cmd_ready), LINE_W'(1));
        cmd_valid = 1'b1;
        cmd_desc  = desc;
        cmd_src   = src;
        cmd_lines = lines;
        auth_ok   = auth_acc;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        auth_ok   = auth_chk;
        check(!loaded && err_code == 2'd0, "R2 cleared on accept",
              LINE_W'({loaded, err_code}), LINE_W'(0));
        check(cmd_ready == 1'b0, "R1 ready low after accept", LINE_W'(cmd_ready), LINE_W'(0));
        @(posedge clk);
        @(negedge clk);
        auth_ok = 1'b0;   // R10: late changes must not matter
        k = 1;
        while (!cmd_ready && k < 10000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [7:0] desc, input logic [31:0] src, input logic [15:0] lines,
                       input logic auth_acc, input logic auth_chk, input logic [1:0] exp_err,
                       input bit timed);
        int k;
        int base;
        int exp_k;
        logic [LINE_W-1:0] d;
        string rq;
        rq = req_of(exp_err);
        base = req_count;
        issue(desc, src, lines, auth_acc, auth_chk, k);
        check(err_code == exp_err, {rq, " err_code"}, LINE_W'(err_code), LINE_W'(exp_err));
        check(loaded == (exp_err == 2'd0), {rq, " loaded"}, LINE_W'(loaded),
              LINE_W'(exp_err == 2'd0));
        exp_k = (exp_err == 2'd0) ? 2 + 2 * int'(lines) : 1;
        if (timed)
            check(k == exp_k, {rq, " R1 completion edge"}, LINE_W'(k), LINE_W'(exp_k));
        check(req_count - base == ((exp_err == 2'd0) ? int'(lines) : 0),
              {rq, " R6 request count"}, LINE_W'(req_count - base),
              LINE_W'((exp_err == 2'd0) ? int'(lines) : 0));
        if (exp_err == 2'd0) begin
            for (int j = 0; j < int'(lines); j++) begin
                exp_ram[j] = img(src + 32'(j * LINE_BYTES), desc);
                known[j] = 1'b1;
                ram_read(j, d);
                check(d == exp_ram[j], "R6 R10 line content", d, exp_ram[j]);
            end
        end else begin
            for (int j = 0; j < 4; j++) begin
                if (known[j]) begin
                    ram_read(j, d);
                    check(d == exp_ram[j], {rq, " no write on abort"}, d, exp_ram[j]);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] d;
        logic [LINE_W-1:0] d1;
        for (int j = 0; j < RAM_LINES; j++) known[j] = 1'b0;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_desc  = 8'd0;
        cmd_src   = '0;
        cmd_lines = '0;
        auth_ok   = 1'b0;
        ex_addr   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !loaded && err_code == 2'd0 && !rd_req_valid, "R1 R2 reset state",
              LINE_W'({cmd_ready, loaded, err_code, rd_req_valid}), LINE_W'(5'b10000));

        // Table of stimulus and expected results.
        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i].desc, VEC[i].src, VEC[i].lines, VEC[i].auth, VEC[i].auth,
                VEC[i].err, 1'b1);
        end

        // R5: authentication low at acceptance but high on the check edge is approved.
        run(8'd11, 32'h0000_3000, 16'd2, 1'b0, 1'b1, 2'd0, 1'b1);
        // R5: high at acceptance, low on the check edge aborts.
        run(8'd12, 32'h0000_4000, 16'd2, 1'b1, 1'b0, 2'd1, 1'b1);

        // R7: stalling responder, contents and count only.
        stall = 1'b1;
        run(8'd33, 32'h0001_0000, 16'd4, 1'b1, 1'b1, 2'd0, 1'b0);
        stall = 1'b0;

        // R4: exactly the RAM capacity is accepted.
        run(8'd77, 32'h0000_0000, 16'd1536, 1'b1, 1'b1, 2'd0, 1'b1);

        // R9: read data appears one edge after the address.
        ram_read(1, d1);
        @(negedge clk);
        ex_addr = IDX_W'(0);
        #1;
        check(ex_data == d1, "R9 no data before edge", ex_data, d1);
        @(posedge clk);
        @(negedge clk);
        d = ex_data;
        check(d == exp_ram[0], "R9 data after one edge", d, exp_ram[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule